// File: doc/BRIEF.md
# Two-Thread Priority Decode-Slot Arbiter

This block decides, every clock cycle, which of two hardware threads may use the single decode slot of a shared core. Software gives each thread a 3-bit priority. A throttling monitor supplies a suspend flag for each thread, and the thread's front end supplies a ready flag. The arbiter drives a one-hot grant and the index of the winning thread. The grant is combinational from the current inputs and the arbiter's window position.

When both priorities lie between 2 and 6, slots are shared in repeating windows. The window is 2^(d+1) cycles long, where d is the priority difference. The higher thread owns every slot of the window except the last one, which belongs to the lower thread. Three priority values select a special mode instead of a ratio:

- 0 switches a thread off.
- 7 gives the core to one thread alone.
- 1 marks a thread that takes only the slots its partner leaves unused. When both threads are at 1, the block enters a sparse low-power cadence.

Thread A is index 0 and thread B is index 1.

Top module: `prio_slot_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant` is 2'b00. Reset puts the window position at 0 and treats both stored priorities as 4.
- R2: `grant` is one-hot or zero. `grantIdx` equals `grant[1]`, which makes it 0 when no grant is issued.
- R3: In ratio mode (both priorities in 2..6, d = |A−B|, window R = 2^(d+1)), the higher thread is owed positions 0..R−2 of each window and the lower thread is owed position R−1. For example, 6 against 2 gives 31 slots to 1.
- R4: With equal priorities in 2..6, R is 2, so slots alternate, and thread A is owed position 0.
- R5: A thread at priority 0 is never granted. The other thread, if it is not at 0 or 7, is owed every cycle and has no partner to fall back to. When both threads are at 0, no grant is issued.
- R6: A thread at priority 7 is owed every cycle, and the other thread is never granted. If both threads are at 7, thread A is the single thread.
- R7: When one thread is at priority 1 and the other is in 2..6, the priority-1 thread is granted only in cycles where the other thread is not usable.
- R8: With both threads at priority 1, the window is 8 cycles. Thread A is owed position 0 and thread B is owed position 4, and no other position grants.
- R9: A thread is usable when it is ready and not suspended. A slot owed to an unusable thread goes to the other thread if that thread is usable and the mode allows sharing; otherwise no grant is issued. The window position advances in every cycle either way.
- R10: When either priority differs from its value in the previous cycle, the window position counts as 0 in that cycle, so the new mode or ratio applies at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prioA | input | 3 | Software priority of thread A (index 0) |
| prioB | input | 3 | Software priority of thread B (index 1) |
| readyA | input | 1 | Thread A has an instruction to decode |
| readyB | input | 1 | Thread B has an instruction to decode |
| suspendA | input | 1 | Throttling monitor holds thread A back |
| suspendB | input | 1 | Throttling monitor holds thread B back |
| grant | output | 2 | One-hot decode-slot grant, bit 0 for thread A |
| grantIdx | output | 1 | Index of the granted thread, 0 when idle |

## Verification
The ratio mode is tried with several priority pairs:

- Equal priorities separate strict alternation from a window-based split.
- 5 against 4 and 6 against 2 separate the window lengths 4 and 32.
- Swapping 6/2 to 2/6 tells which thread holds the last slot.

Ready and suspend patterns held low in chosen cycles show that an owed slot spills to the partner while the window keeps advancing. With priority 0, 1 and 7 paired against ordinary priorities, and with both threads at 1, the mode decode is separated from the ratio arithmetic. Changing the priorities in the middle of a window shows that the window restarts from its first position.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_SOLO,
    MODE_RATIO,
    MODE_LEFT,
    MODE_LOWPWR
  } arbMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic slotOpen;  // a slot may be granted this cycle
    logic owed;      // thread index owed the slot
    logic spillOk;   // partner may take an unused slot
  } slotCtl_t;

endpackage

// File: rtl/arb_slot_ctrl.sv
module arb_slot_ctrl
  import prio_arb_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int LP_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIO_W-1:0] prioA,
  input  logic [PRIO_W-1:0] prioB,
  output slotCtl_t          ctl
);

  localparam int PRIO_MAX   = (1 << PRIO_W) - 1;
  localparam int RATIO_CW   = PRIO_MAX - 2;            // widest window 2^(PRIO_MAX-2)
  localparam int LP_CW      = $clog2(2 * LP_GAP);
  localparam int CNT_W      = (RATIO_CW > LP_CW) ? RATIO_CW : LP_CW;
  localparam logic [PRIO_W-1:0] P_OFF  = '0;
  localparam logic [PRIO_W-1:0] P_LEFT = PRIO_W'(1);
  localparam logic [PRIO_W-1:0] P_SOLO = PRIO_W'(PRIO_MAX);
  localparam logic [PRIO_W-1:0] P_DFLT = PRIO_W'(1 << (PRIO_W - 1));
  localparam logic [CNT_W-1:0]  LP_LIM = CNT_W'(2 * LP_GAP - 1);
  localparam logic [CNT_W-1:0]  LP_MID = CNT_W'(LP_GAP);

  logic [PRIO_W-1:0] prevA, prevB, diff;
  logic [CNT_W-1:0]  cnt, pos, limit;
  logic [CNT_W:0]    span;
  logic              aHigher, changed, highIdx;
  arbMode_e          mode;

  assign aHigher = (prioA >= prioB);
  assign highIdx = ~aHigher;
  assign diff    = aHigher ? (prioA - prioB) : (prioB - prioA);
  assign changed = (prioA != prevA) || (prioB != prevB);
  assign pos     = changed ? '0 : cnt;
  assign span    = (CNT_W + 1)'(1) << (diff + PRIO_W'(1));

  always_comb begin
    if (prioA == P_SOLO || prioB == P_SOLO)      mode = MODE_SOLO;
    else if (prioA == P_OFF || prioB == P_OFF)   mode = MODE_OFF;
    else if (prioA == P_LEFT && prioB == P_LEFT) mode = MODE_LOWPWR;
    else if (prioA == P_LEFT || prioB == P_LEFT) mode = MODE_LEFT;
    else                                         mode = MODE_RATIO;
  end

  always_comb begin
    case (mode)
      MODE_RATIO:  limit = CNT_W'(span - (CNT_W + 1)'(1));
      MODE_LOWPWR: limit = LP_LIM;
      default:     limit = '0;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (mode)
      MODE_SOLO: begin
        ctl.slotOpen = 1'b1;
        ctl.owed     = (prioA != P_SOLO);
        ctl.spillOk  = 1'b0;
      end
      MODE_OFF: begin
        ctl.slotOpen = !(prioA == P_OFF && prioB == P_OFF);
        ctl.owed     = (prioA == P_OFF);
        ctl.spillOk  = 1'b0;
      end
      MODE_LOWPWR: begin
        ctl.slotOpen = (pos == '0) || (pos == LP_MID);
        ctl.owed     = (pos >= LP_MID);
        ctl.spillOk  = 1'b1;
      end
      MODE_LEFT: begin
        ctl.slotOpen = 1'b1;
        ctl.owed     = (prioA == P_LEFT);
        ctl.spillOk  = 1'b1;
      end
      default: begin
        ctl.slotOpen = 1'b1;
        ctl.owed     = (pos == limit) ? ~highIdx : highIdx;
        ctl.spillOk  = 1'b1;
      end
    endcase
    ctl.slotOpen = ctl.slotOpen & rst_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      prevA <= P_DFLT;
      prevB <= P_DFLT;
    end else begin
      cnt   <= (pos == limit) ? '0 : pos + CNT_W'(1);
      prevA <= prioA;
      prevB <= prioB;
    end
  end

endmodule

// File: rtl/arb_slot_dp.sv
module arb_slot_dp
  import prio_arb_pkg::*;
#(
  parameter int N_THR = 2
) (
  input  slotCtl_t         ctl,
  input  logic [N_THR-1:0] ready,
  input  logic [N_THR-1:0] suspend,
  output logic [N_THR-1:0] grant,
  output logic             grantIdx
);

  logic [N_THR-1:0] usable;

  for (genvar t = 0; t < N_THR; t++) begin : g_use
    assign usable[t] = ready[t] & ~suspend[t];
  end

  logic other;
  assign other = ~ctl.owed;

  always_comb begin
    grant = '0;
    if (ctl.slotOpen) begin
      if (usable[ctl.owed])                grant[ctl.owed] = 1'b1;
      else if (ctl.spillOk && usable[other]) grant[other]  = 1'b1;
    end
  end

  assign grantIdx = grant[1];

endmodule

// File: rtl/prio_slot_arbiter.sv
module prio_slot_arbiter
  import prio_arb_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int LP_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PRIO_W-1:0] prioA,
  input  logic [PRIO_W-1:0] prioB,
  input  logic              readyA,
  input  logic              readyB,
  input  logic              suspendA,
  input  logic              suspendB,
  output logic [1:0]        grant,
  output logic              grantIdx
);

  slotCtl_t ctl;

  arb_slot_ctrl #(.PRIO_W(PRIO_W), .LP_GAP(LP_GAP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .prioA(prioA), .prioB(prioB), .ctl(ctl)
  );

  arb_slot_dp #(.N_THR(2)) u_dp (
    .ctl(ctl), .ready({readyB, readyA}), .suspend({suspendB, suspendA}),
    .grant(grant), .grantIdx(grantIdx)
  );

endmodule

// File: rtl/arb_slot_checker.sv
module arb_slot_checker #(
  parameter int PRIO_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PRIO_W-1:0] prioA,
  input logic [PRIO_W-1:0] prioB,
  input logic              readyA,
  input logic              readyB,
  input logic              suspendA,
  input logic              suspendB,
  input logic [1:0]        grant,
  input logic              grantIdx
);

  localparam logic [PRIO_W-1:0] P_SOLO = PRIO_W'((1 << PRIO_W) - 1);
  localparam logic [PRIO_W-1:0] P_LEFT = PRIO_W'(1);

  logic bothLeft, useA, useB, plainB, plainA;
  assign bothLeft = (prioA == P_LEFT) && (prioB == P_LEFT);
  assign useA     = readyA && !suspendA;
  assign useB     = readyB && !suspendB;
  assign plainA   = (prioA > P_LEFT) && (prioA < P_SOLO);
  assign plainB   = (prioB > P_LEFT) && (prioB < P_SOLO);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> grant == 2'b00);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grantIdx == grant[1]);

  p_off_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prioA == '0 |-> !grant[0]);

  p_off_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prioB == '0 |-> !grant[1]);

  p_solo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prioA == P_SOLO |-> !grant[1]);

  p_leftover_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prioA == P_LEFT && plainB && useB) |-> !grant[0]);

  p_leftover_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prioB == P_LEFT && plainA && useA) |-> !grant[1]);

  p_lowpwr_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bothLeft && grant != 2'b00) |=> (!bothLeft || grant == 2'b00));

endmodule

bind prio_slot_arbiter arb_slot_checker #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prioA(prioA), .prioB(prioB),
  .readyA(readyA), .readyB(readyB), .suspendA(suspendA), .suspendB(suspendB),
  .grant(grant), .grantIdx(grantIdx)
);

// File: tb/tb_prio_slot_arbiter.sv
module tb_prio_slot_arbiter;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [2:0] prioA = 3'd4, prioB = 3'd4;
  logic       readyA = 1'b0, readyB = 1'b0, suspendA = 1'b0, suspendB = 1'b0;
  logic [1:0] grant;
  logic       grantIdx;

  prio_slot_arbiter dut (
    .clk(clk), .rst_n(rst_n), .prioA(prioA), .prioB(prioB),
    .readyA(readyA), .readyB(readyB), .suspendA(suspendA), .suspendB(suspendB),
    .grant(grant), .grantIdx(grantIdx)
  );

  typedef struct {
    logic [1:0] g;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0;
  int   mCnt = 0;
  int   mPa = 4, mPb = 4;
  bit   done = 0;

  // expected grant from the requirements; model state steps once per cycle
  task automatic step(input bit rv, input int pa, input int pb,
                      input bit ra, input bit rb, input bit sa, input bit sb,
                      input string tag, input int n = 1);
    for (int k = 0; k < n; k++) begin
      int pos, lim, owed, hi;
      bit open, spill;
      logic [1:0] use_, g;
      exp_t e;
      @(negedge clk);
      rst_n = rv; prioA = 3'(pa); prioB = 3'(pb);
      readyA = ra; readyB = rb; suspendA = sa; suspendB = sb;
      g = 2'b00;
      if (!rv) begin
        mCnt = 0; mPa = 4; mPb = 4;
      end else begin
        pos = (pa != mPa || pb != mPb) ? 0 : mCnt;
        lim = 0; owed = 0; open = 1; spill = 1;
        use_ = {rb & ~sb, ra & ~sa};
        if (pa == 7) begin owed = 0; spill = 0; end
        else if (pb == 7) begin owed = 1; spill = 0; end
        else if (pa == 0 || pb == 0) begin
          open = !(pa == 0 && pb == 0); owed = (pa == 0) ? 1 : 0; spill = 0;
        end else if (pa == 1 && pb == 1) begin
          lim = 7; open = (pos == 0 || pos == 4); owed = (pos >= 4) ? 1 : 0;
        end else if (pa == 1 || pb == 1) begin
          owed = (pa == 1) ? 1 : 0;
        end else begin
          lim  = (1 << (((pa > pb) ? pa - pb : pb - pa) + 1)) - 1;
          hi   = (pa >= pb) ? 0 : 1;
          owed = (pos == lim) ? 1 - hi : hi;
        end
        if (open) begin
          if (use_[owed]) g[owed] = 1'b1;
          else if (spill && use_[1-owed]) g[1-owed] = 1'b1;
        end
        mCnt = (pos == lim) ? 0 : pos + 1;
        mPa = pa; mPb = pb;
      end
      e.g = g; e.tag = tag;
      q.push_back(e);
    end
  endtask

  // monitor: compares mid low phase, after inputs settle
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (grant !== e.g || grantIdx !== e.g[1]) begin
          bad++;
          $display("FAIL %s: grant=%b idx=%b expected grant=%b idx=%b",
                   e.tag, grant, grantIdx, e.g, e.g[1]);
        end
      end
    end
  end

  initial begin
    // R1: reset holds grant low even with both threads ready
    step(0, 4, 4, 1, 1, 0, 0, "R1", 3);
    // R4: equal priorities alternate, A first
    step(1, 4, 4, 1, 1, 0, 0, "R4", 8);
    step(1, 3, 3, 1, 1, 0, 0, "R4 R10", 5);
    // R3: 5/4 window of 4, 6/2 window of 32, then swapped
    step(1, 5, 4, 1, 1, 0, 0, "R3", 16);
    step(1, 6, 2, 1, 1, 0, 0, "R3", 66);
    step(1, 2, 6, 1, 1, 0, 0, "R3 R10", 40);
    // R10: change in the middle of a window
    step(1, 4, 2, 1, 1, 0, 0, "R10", 5);
    step(1, 2, 4, 1, 1, 0, 0, "R10", 10);
    // R9: unusable owner spills, window keeps moving
    step(1, 6, 3, 1, 1, 0, 0, "R9", 3);
    step(1, 6, 3, 0, 1, 0, 0, "R9", 4);
    step(1, 6, 3, 1, 1, 1, 0, "R9", 2);
    step(1, 6, 3, 1, 1, 0, 0, "R9", 12);
    step(1, 6, 3, 1, 0, 0, 0, "R9", 5);
    step(1, 6, 3, 0, 0, 0, 0, "R9", 3);
    step(1, 3, 3, 1, 1, 0, 1, "R9", 4);
    // R5: thread off
    step(1, 0, 5, 1, 1, 0, 0, "R5", 6);
    step(1, 0, 5, 1, 0, 0, 0, "R5", 3);
    step(1, 3, 0, 1, 1, 0, 0, "R5", 4);
    step(1, 0, 0, 1, 1, 0, 0, "R5", 3);
    // R6: single-thread mode
    step(1, 7, 3, 1, 1, 0, 0, "R6", 4);
    step(1, 7, 3, 0, 1, 0, 0, "R6", 3);
    step(1, 3, 7, 1, 1, 0, 0, "R6", 4);
    step(1, 7, 7, 1, 1, 0, 0, "R6", 3);
    step(1, 0, 7, 1, 1, 0, 0, "R6 R5", 3);
    // R7: leftover-only thread
    step(1, 1, 4, 1, 1, 0, 0, "R7", 5);
    step(1, 1, 4, 1, 0, 0, 0, "R7", 3);
    step(1, 1, 4, 1, 1, 0, 1, "R7", 2);
    step(1, 6, 1, 1, 1, 0, 0, "R7", 4);
    step(1, 6, 1, 0, 1, 0, 0, "R7", 3);
    // R8: low-power cadence
    step(1, 1, 1, 1, 1, 0, 0, "R8", 20);
    step(1, 1, 1, 0, 1, 0, 0, "R8 R9", 10);
    step(1, 1, 1, 1, 1, 0, 0, "R8", 6);
    // R2 and R1 again after a late reset
    step(1, 5, 5, 1, 1, 0, 0, "R2", 6);
    step(0, 5, 5, 1, 1, 0, 0, "R1", 2);
    step(1, 4, 4, 1, 1, 0, 0, "R1 R4", 4);
    @(negedge clk);
    #8;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule